// File: doc/BRIEF.md
# Elitist Single-Parent Evolution Sequencer

This block runs the control loop of a (1+λ) evolution strategy over a chromosome held in registers. A pulse on `start` captures a seed, a mutation rate and a target score, then builds the first generation of λ individuals with every gene drawn at random. Each individual is offered to an external scorer through a request/acknowledge pair. The best one becomes the parent. Every later generation is made of λ mutated copies of the parent. The best of those copies replaces the parent when it scores at least as well, so equal scores allow neutral drift.

The chromosome is a flat vector of genes of `GW` bits each. Gene i occupies bits `[i*GW +: GW]`. Genes 0 to NCELL-1 are cell function codes. Genes NCELL to 2*NCELL-1 are cell source offsets inside the level-back window. The last NOUT genes select which cells drive the outputs. Random values come from a 16-bit LFSR and are folded by a modulo into the legal range of the gene they land in. The loop ends when the scorer reports a fully working circuit whose score meets the target, or when the generation limit is reached. The block then holds `done` together with the winning chromosome and the generation count.

Top module: `es_engine`

## Requirements
- R1: After reset, `done`, `hit` and `ev_start` are 0 and `gen_cnt` is 0.
- R2: In generation 0, every gene of every individual is randomized whatever the rate, so with rate 0 the λ initial individuals are not all identical.
- R3: Every chromosome offered for scoring is legal. Function genes (indices 0..NCELL-1) are below NFUNC, source genes (NCELL..2*NCELL-1) are below LBACK, and output genes (2*NCELL..) are below NCELL.
- R4: With rate 0, every individual of generation 1 or later is an exact copy of the current parent.
- R5: A gene of an offspring is redrawn when an LFSR byte is below the 8-bit rate (rate/256 per gene). A larger rate gives more genes that differ from the parent.
- R6: The ranking key is {ev_ok, ev_score}. The best of generation 0 becomes the parent. Later, the best offspring replaces the parent only if its key is greater than or equal to the parent's key, so worse offspring never displace it.
- R7: On equal keys, the later individual wins, both among offspring and against the parent.
- R8: When a response has ev_ok=1 and ev_score >= target, the run stops at once. `done` and `hit` become 1, `win_chrom` is that chromosome, `gen_cnt` is its 0-based generation index, and no further request is issued.
- R9: Without such a response, the run stops after MAX_GEN generations, that is λ*MAX_GEN requests. It ends with `hit`=0, `gen_cnt`=MAX_GEN and `win_chrom` equal to the parent.
- R10: `ev_start` is a one-cycle pulse. `ev_chrom` holds steady until `ev_done`, and only one request is outstanding at a time.
- R11: Equal seeds give equal runs, and a seed of 0 behaves as a seed of 1.
- R12: Once `done` is set, it stays set and `win_chrom` stays stable until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| seed | input | 16 | LFSR seed, captured on start |
| rate | input | 8 | Per-gene mutation rate as a fraction of 256 |
| target | input | SW | Score that ends the run when ev_ok is also 1 |
| ev_start | output | 1 | One-cycle request to score ev_chrom |
| ev_chrom | output | CW | Chromosome under evaluation |
| ev_done | input | 1 | Scorer response strobe |
| ev_ok | input | 1 | Circuit is fully functional |
| ev_score | input | SW | Optimization score |
| done | output | 1 | Run finished |
| hit | output | 1 | Run ended on the target |
| win_chrom | output | CW | Parent / winning chromosome |
| gen_cnt | output | GNW | Generation index of the win, or MAX_GEN |

## Verification
The bench builds the block with two cells, one output, five function codes, a window of three, 3-bit genes, λ=3 and a limit of six generations. With these values every run finishes in a few hundred cycles. The bench can then check the legality of every gene of every request and follow the parent selection request by request. It runs a constant, a chromosome-derived, a falling and a target-hitting scorer, which covers ties, rejection of worse offspring, early stops in generation 0 and in a later generation, and the limit.

// File: rtl/es_engine.sv
module es_engine #(
  parameter int NCELL   = 100,
  parameter int NOUT    = 4,
  parameter int NFUNC   = 5,
  parameter int LBACK   = 10,
  parameter int GW      = 7,
  parameter int LAMBDA  = 5,
  parameter int MAX_GEN = 5000,
  parameter int SW      = 8,
  localparam int NG  = 2*NCELL + NOUT,
  localparam int CW  = NG*GW,
  localparam int GNW = $clog2(MAX_GEN+1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [15:0]    seed,
  input  logic [7:0]     rate,
  input  logic [SW-1:0]  target,
  output logic           ev_start,
  output logic [CW-1:0]  ev_chrom,
  input  logic           ev_done,
  input  logic           ev_ok,
  input  logic [SW-1:0]  ev_score,
  output logic           done,
  output logic           hit,
  output logic [CW-1:0]  win_chrom,
  output logic [GNW-1:0] gen_cnt
);
  localparam int GIW = $clog2(NG+1);
  localparam int IW  = $clog2(LAMBDA+1);
  localparam int KW  = SW+1;

  typedef enum logic [1:0] {S_IDLE, S_MUT, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [15:0]    lfsr;
  logic [7:0]     rate_q;
  logic [SW-1:0]  tgt_q;
  logic           init_q, done_q, hit_q;
  logic [GIW-1:0] gi;
  logic [IW-1:0]  idx;
  logic [GNW-1:0] gen;
  logic [CW-1:0]  par, best, cand;
  logic [KW-1:0]  par_key, best_key;

  wire [15:0]   lfsr_n = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  wire [31:0]   rb     = 32'(lfsr[15:8]);
  wire [GW-1:0] v_fn   = GW'(rb % NFUNC);
  wire [GW-1:0] v_sr   = GW'(rb % LBACK);
  wire [GW-1:0] v_out  = GW'(rb % NCELL);
  wire [GW-1:0] v_new  = (32'(gi) < NCELL) ? v_fn : (32'(gi) < 2*NCELL) ? v_sr : v_out;
  wire          mut    = init_q || (lfsr[7:0] < rate_q);
  wire [GW-1:0] p_gene = par[32'(gi)*GW +: GW];

  wire [KW-1:0] key     = {ev_ok, ev_score};
  wire          take    = (idx == '0) || (key >= best_key);
  wire [CW-1:0] nb      = take ? cand : best;
  wire [KW-1:0] nbk     = take ? key : best_key;
  wire          hit_now = ev_ok && (ev_score >= tgt_q);
  wire          last_i  = idx == IW'(LAMBDA-1);
  wire          promote = init_q || (nbk >= par_key);
  wire [GNW-1:0] gen_nx = gen + 1'b1;
  wire          last_g  = gen_nx == GNW'(MAX_GEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  lfsr <= 16'h1;  rate_q <= '0;  tgt_q <= '0;
      init_q <= 1'b0;  done_q <= 1'b0;  hit_q <= 1'b0;
      gi <= '0;  idx <= '0;  gen <= '0;
      par <= '0;  best <= '0;  cand <= '0;  par_key <= '0;  best_key <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          lfsr   <= (seed == 16'h0) ? 16'h1 : seed;
          rate_q <= rate;
          tgt_q  <= target;
          init_q <= 1'b1;  done_q <= 1'b0;  hit_q <= 1'b0;
          gi <= '0;  idx <= '0;  gen <= '0;
          st <= S_MUT;
        end
        S_MUT: begin
          cand[32'(gi)*GW +: GW] <= mut ? v_new : p_gene;
          lfsr <= lfsr_n;
          if (gi == GIW'(NG-1)) begin
            gi <= '0;
            st <= S_REQ;
          end else gi <= gi + 1'b1;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (ev_done) begin
          best <= nb;  best_key <= nbk;
          if (hit_now) begin
            par <= cand;  par_key <= key;
            done_q <= 1'b1;  hit_q <= 1'b1;
            st <= S_IDLE;
          end else if (last_i) begin
            idx <= '0;  init_q <= 1'b0;
            if (promote) begin
              par <= nb;  par_key <= nbk;
            end
            gen <= gen_nx;
            if (last_g) begin
              done_q <= 1'b1;
              st <= S_IDLE;
            end else st <= S_MUT;
          end else begin
            idx <= idx + 1'b1;
            st <= S_MUT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ev_start  = (st == S_REQ);
  assign ev_chrom  = cand;
  assign done      = done_q;
  assign hit       = hit_q;
  assign win_chrom = par;
  assign gen_cnt   = gen;

  function automatic logic legal(input logic [CW-1:0] c);
    legal = 1'b1;
    for (int i = 0; i < NG; i++) begin
      if (i < NCELL) begin
        if (32'(c[i*GW +: GW]) >= NFUNC) legal = 1'b0;
      end else if (i < 2*NCELL) begin
        if (32'(c[i*GW +: GW]) >= LBACK) legal = 1'b0;
      end else begin
        if (32'(c[i*GW +: GW]) >= NCELL) legal = 1'b0;
      end
    end
  endfunction

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ev_start |=> !ev_start); // R10
  AST_CHROM_HELD: assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT && !ev_done) |=> $stable(ev_chrom)); // R10
  AST_LEGAL_GENES: assert property (@(posedge clk) disable iff (!rst_n) ev_start |-> legal(ev_chrom)); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> (done && $stable(win_chrom))); // R12
  AST_GEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) gen_cnt <= GNW'(MAX_GEN)); // R9
  AST_HIT_DONE: assert property (@(posedge clk) disable iff (!rst_n) hit |-> done); // R8
  AST_QUIET_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ev_start); // R8
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 16'h0); // R11
endmodule

// File: tb/test_es_engine.sv
module test_es_engine;
  localparam int CLK_PER = 10;
  localparam int NCELL = 2, NOUT = 1, NFUNC = 5, LBACK = 3, GW = 3;
  localparam int LAMBDA = 3, MAX_GEN = 6, SW = 8, LAT = 2;
  localparam int NG = 2*NCELL + NOUT, CW = NG*GW, GNW = $clog2(MAX_GEN+1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] seed = 0;
  logic [7:0] rate = 0;
  logic [SW-1:0] target = 8'd200;
  logic ev_start, ev_done = 0, ev_ok = 0;
  logic [SW-1:0] ev_score = 0;
  logic [CW-1:0] ev_chrom, win_chrom;
  logic done, hit;
  logic [GNW-1:0] gen_cnt;

  int checks = 0, errors = 0;
  int mode = 0, hitn = -1;
  int n_ev, legal_err, hold_err, r0_err, diff_genes, init_distinct;
  logic [63:0] hsh;
  logic [CW-1:0] first_c, last_c, hit_c, mp, mb;
  logic [SW:0] mpk, mbk;
  logic [CW-1:0] g0 [LAMBDA];

  always #(CLK_PER/2) clk = ~clk;

  es_engine #(.NCELL(NCELL), .NOUT(NOUT), .NFUNC(NFUNC), .LBACK(LBACK), .GW(GW),
              .LAMBDA(LAMBDA), .MAX_GEN(MAX_GEN), .SW(SW)) i_es_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .rate(rate), .target(target),
    .ev_start(ev_start), .ev_chrom(ev_chrom), .ev_done(ev_done), .ev_ok(ev_ok),
    .ev_score(ev_score), .done(done), .hit(hit), .win_chrom(win_chrom), .gen_cnt(gen_cnt));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (ev_start) begin
        automatic logic [CW-1:0] c = ev_chrom;
        automatic int g = n_ev / LAMBDA, i = n_ev % LAMBDA;
        automatic logic ok = 0;
        automatic logic [SW-1:0] sc = 8'd7;
        for (int k = 0; k < NG; k++) begin
          automatic int v = int'(c[k*GW +: GW]);
          automatic int lim = (k < NCELL) ? NFUNC : (k < 2*NCELL) ? LBACK : NCELL;
          if (v >= lim) legal_err++;
          if (g > 0 && c[k*GW +: GW] != mp[k*GW +: GW]) diff_genes++;
        end
        if (g > 0 && rate == 0 && c != mp) r0_err++;
        if (g == 0) g0[i] = c;
        if (n_ev == 0) first_c = c;
        last_c = c;
        hsh = {hsh[61:0], hsh[63:62]} ^ 64'(c);
        case (mode)
          1: sc = 8'(c % 200);
          2: if (n_ev == hitn) begin ok = 1; sc = target; hit_c = c; end
          3: sc = 8'(200 - n_ev);
          default: sc = 8'd7;
        endcase
        repeat (LAT) begin
          @(negedge clk);
          if (ev_start) hold_err++;
          if (ev_chrom != c) hold_err++;
        end
        ev_ok = ok; ev_score = sc; ev_done = 1;
        if (i == 0 || {ok, sc} >= mbk) begin mb = c; mbk = {ok, sc}; end
        if (i == LAMBDA-1 && (g == 0 || mbk >= mpk)) begin mp = mb; mpk = mbk; end
        n_ev++;
        @(negedge clk);
        ev_done = 0; ev_ok = 0; ev_score = 0;
      end
    end
  end

  task automatic run(input logic [15:0] s, input logic [7:0] r, input int m, input int hn);
    automatic int t = 0;
    n_ev = 0; legal_err = 0; hold_err = 0; r0_err = 0; diff_genes = 0; hsh = 0;
    mpk = 0; mbk = 0; mp = 0; mb = 0;
    mode = m; hitn = hn; seed = s; rate = r;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, "R9 run finished", 64'(done), 64'd1);
    init_distinct = 0;
    for (int a = 1; a < LAMBDA; a++) if (g0[a] != g0[0]) init_distinct = 1;
    chk(legal_err == 0, "R3 legal genes", 64'(legal_err), 0);
    chk(hold_err == 0, "R10 handshake", 64'(hold_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !hit && !ev_start && gen_cnt == 0, "R1 reset state",
        64'({done, hit, ev_start, gen_cnt}), 0);
    rst_n = 1;

    run(16'h1234, 8'd0, 1, -1);
    chk(init_distinct == 1, "R2 initial randomized", 64'(init_distinct), 1);
    chk(r0_err == 0, "R4 rate zero copies", 64'(r0_err), 0);
    chk(diff_genes == 0, "R4 no differing genes", 64'(diff_genes), 0);
    chk(n_ev == LAMBDA*MAX_GEN, "R9 request count", 64'(n_ev), 64'(LAMBDA*MAX_GEN));
    chk(!hit && gen_cnt == GNW'(MAX_GEN), "R9 limit end", 64'({hit, gen_cnt}), 64'(MAX_GEN));

    run(16'h5a5a, 8'd64, 1, -1);
    chk(win_chrom == mp, "R6 elitist parent", 64'(win_chrom), 64'(mp));
    begin
      automatic logic [CW-1:0] w = win_chrom;
      repeat (20) @(negedge clk);
      chk(done && win_chrom == w && !ev_start, "R12 done held", 64'(win_chrom), 64'(w));
    end

    run(16'hbeef, 8'd128, 3, -1);
    chk(win_chrom == first_c, "R6 worse offspring rejected", 64'(win_chrom), 64'(first_c));
    chk(diff_genes >= 10 && diff_genes <= 50, "R5 rate 128 mutation share", 64'(diff_genes), 64'd26);

    begin
      automatic int d128;
      run(16'h0777, 8'd128, 0, -1);
      chk(win_chrom == last_c, "R7 tie goes to latest", 64'(win_chrom), 64'(last_c));
      d128 = diff_genes;
      run(16'h0777, 8'd255, 0, -1);
      chk(diff_genes > d128, "R5 higher rate more change", 64'(diff_genes), 64'(d128));
    end

    run(16'h4321, 8'd100, 2, 7);
    chk(hit && gen_cnt == 2, "R8 early stop gen", 64'({hit, gen_cnt}), 64'({1'b1, 3'd2}));
    chk(win_chrom == hit_c, "R8 winner", 64'(win_chrom), 64'(hit_c));
    chk(n_ev == 8, "R8 no further request", 64'(n_ev), 8);

    run(16'h4321, 8'd100, 2, 0);
    chk(hit && gen_cnt == 0 && n_ev == 1, "R8 stop in generation 0",
        64'({hit, gen_cnt, 8'(n_ev)}), 64'({1'b1, 3'd0, 8'd1}));

    begin
      automatic logic [63:0] h1;
      automatic logic [CW-1:0] w1;
      run(16'h9999, 8'd90, 1, -1); h1 = hsh; w1 = win_chrom;
      run(16'h9999, 8'd90, 1, -1);
      chk(hsh == h1 && win_chrom == w1, "R11 repeatable seed", hsh, h1);
      run(16'h0001, 8'd90, 1, -1); h1 = hsh;
      run(16'h0000, 8'd90, 1, -1);
      chk(hsh == h1, "R11 zero seed as one", hsh, h1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule